// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

This controller carries out a move-multiple operation between an eight-entry floating-point register file and memory. The caller gives it a start address, a register selection mask and a direction. It also gives a two-bit mode field, a beat format and a flag that says whether the address register is updated. The sequencer then issues one memory beat for each selected register. Each beat is a request/ready handshake that carries the register index, the byte address and the beat size. When the last beat is accepted, the sequencer returns the final address so that the caller can write it back.

Two things depend on the mode field. The first is the order in which registers are visited: ascending with a rising address, or descending with a falling address. The second is where the mask comes from: either a static mask taken from the instruction extension word, or the low byte of a data register chosen at run time. In descending order the address does not move after the last selected register, so the final address points at the lowest register that was written. Unselected registers take no cycles.

Top module: `fpr_burst_seq`

## Requirements
- R1: The mask source is selected by `ext_mode_i[0]`. When it is 1 the mask is `reg_mask_i`; when it is 0 the mask is `ext_mask_i`. The input that is not selected has no effect on any beat.
- R2: `ext_dir_i` = 1 means a store and drives `mem_write_o` high on every beat; 0 means a load. Descending order is used only when `ext_dir_i` = 1 and `ext_mode_i[1]` = 0. Every other combination uses ascending order.
- R3: In ascending order, register i is selected by mask bit 7-i. Selected registers are visited from 0 up to 7. The first beat uses the start address, each accepted beat adds the beat size, and the final address is start + n*size for n selected registers.
- R4: In descending order, register i is selected by mask bit i. Selected registers are visited from 7 down to 0. The first beat uses the start address, and each accepted beat subtracts the beat size except the last one. The final address is start - (n-1)*size.
- R5: `mem_size_o` is 12 when `wide_fmt_i` was 1 at start, and 8 when it was 0.
- R6: While `mem_req_o` is high and `mem_ready_i` is low, the request, index and address stay unchanged. The sequencer advances only on a cycle where both are high.
- R7: An all-zero mask issues no beat. `done_o` pulses in the second cycle after start, and `final_addr_o` equals the start address.
- R8: `busy_o` is high from the cycle after start until `done_o` rises. `done_o` is a single-cycle pulse with `busy_o` low. A start pulse while busy is ignored.
- R9: `wb_en_o` is high exactly with `done_o` when `ea_update_i` was 1 at start, and low otherwise.
- R10: Synchronous reset clears `busy_o`, `done_o`, `wb_en_o` and `mem_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (taken when idle) |
| ext_dir_i | input | 1 | 1 = store registers to memory, 0 = load |
| ext_mode_i | input | 2 | Bit 0: mask from data register; bit 1: forces ascending order for stores |
| ext_mask_i | input | NREG | Static mask from the extension word |
| reg_mask_i | input | NREG | Low bits of the data register used as the run-time mask |
| base_addr_i | input | AW | Start address |
| wide_fmt_i | input | 1 | 1 = extended (12-byte) beats, 0 = double (8-byte) beats |
| ea_update_i | input | 1 | Addressing mode updates the address register |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| final_addr_o | output | AW | Address for write-back, valid from done |
| wb_en_o | output | 1 | Write-back enable, valid with done |
| mem_req_o | output | 1 | Beat request |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_write_o | output | 1 | Beat is a store |
| mem_idx_o | output | IDX_W | Register index of the beat |
| mem_addr_o | output | AW | Byte address of the beat |
| mem_size_o | output | SZ_W | Beat size in bytes |

## Verification
The bench sweeps all 256 mask values for each combination of direction, order bit, mask-source bit and beat format. It checks every beat index and address against a sequence computed from the mask. The ascending and descending cases separate the bit-reversed mapping from the direct one, and the skipped final decrement from the full increment. In each run the unselected mask input carries the inverse of the real mask, so a wrong source selection changes the visited registers. Ready is stalled in a pseudo-random pattern to test hold-while-waiting, and one run sends a stray start during a transfer.

// File: rtl/fpr_burst_pkg.sv
package fpr_burst_pkg;
  // mode field bit meanings
  localparam int MODE_DYN_BIT = 0;  // mask comes from a data register
  localparam int MODE_ASC_BIT = 1;  // ascending order even for stores

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpr_burst_decode.sv
module fpr_burst_decode
  import fpr_burst_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            dir_store_i,
  input  logic [1:0]      mode_i,
  input  logic [NREG-1:0] ext_mask_i,
  input  logic [NREG-1:0] reg_mask_i,
  output logic            store_o,
  output logic            desc_o,
  output logic [NREG-1:0] sel_o      // indexed by register number
);
  logic [NREG-1:0] raw_mask;

  assign raw_mask = mode_i[MODE_DYN_BIT] ? reg_mask_i : ext_mask_i;
  assign store_o  = dir_store_i;
  assign desc_o   = dir_store_i & ~mode_i[MODE_ASC_BIT];

  // descending: register i <- mask bit i; ascending: register i <- bit NREG-1-i
  for (genvar g = 0; g < NREG; g++) begin : g_norm
    assign sel_o[g] = desc_o ? raw_mask[g] : raw_mask[NREG-1-g];
  end
endmodule

// File: rtl/fpr_burst_pick.sv
module fpr_burst_pick #(
  parameter int NREG  = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pend_i,
  input  logic             desc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic found;

  always_comb begin
    idx_o = '0;
    found = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      int j;
      j = desc_i ? (NREG - 1 - k) : k;
      if (!found && pend_i[j]) begin
        idx_o = j[IDX_W-1:0];
        found = 1'b1;
      end
    end
  end

  assign last_o = ($countones(pend_i) == 1);
endmodule

// File: rtl/fpr_burst_step.sv
module fpr_burst_step #(
  parameter int AW   = 32,
  parameter int SZ_W = 4
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            desc_i,
  input  logic            last_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] size_ext;

  assign size_ext = {{(AW-SZ_W){1'b0}}, size_i};

  always_comb begin
    if (!desc_i)     addr_o = addr_i + size_ext;
    else if (last_i) addr_o = addr_i;
    else             addr_o = addr_i - size_ext;
  end
endmodule

// File: rtl/fpr_burst_seq.sv
module fpr_burst_seq
  import fpr_burst_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int AW        = 32,
  parameter int EXT_BYTES = 12,
  parameter int DBL_BYTES = 8,
  localparam int IDX_W    = $clog2(NREG),
  localparam int SZ_W     = $clog2(max_int(EXT_BYTES, DBL_BYTES) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ext_dir_i,
  input  logic [1:0]       ext_mode_i,
  input  logic [NREG-1:0]  ext_mask_i,
  input  logic [NREG-1:0]  reg_mask_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic             wide_fmt_i,
  input  logic             ea_update_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    final_addr_o,
  output logic             wb_en_o,
  output logic             mem_req_o,
  input  logic             mem_ready_i,
  output logic             mem_write_o,
  output logic [IDX_W-1:0] mem_idx_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [SZ_W-1:0]  mem_size_o
);
  localparam logic [SZ_W-1:0] SZ_EXT = SZ_W'(EXT_BYTES);
  localparam logic [SZ_W-1:0] SZ_DBL = SZ_W'(DBL_BYTES);

  logic            busy_q, done_q, wb_q;
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   addr_q, fin_q;
  logic            desc_q, store_q, wide_q, upd_q;

  logic            store_w, desc_w;
  logic [NREG-1:0] sel_w;
  logic [IDX_W-1:0] pick_idx;
  logic            pick_last;
  logic [AW-1:0]   next_addr;
  logic [SZ_W-1:0] beat_sz;

  fpr_burst_decode #(.NREG(NREG)) u_dec (
    .dir_store_i (ext_dir_i),
    .mode_i      (ext_mode_i),
    .ext_mask_i  (ext_mask_i),
    .reg_mask_i  (reg_mask_i),
    .store_o     (store_w),
    .desc_o      (desc_w),
    .sel_o       (sel_w)
  );

  fpr_burst_pick #(.NREG(NREG)) u_pick (
    .pend_i (pend_q),
    .desc_i (desc_q),
    .idx_o  (pick_idx),
    .last_o (pick_last)
  );

  assign beat_sz = wide_q ? SZ_EXT : SZ_DBL;

  fpr_burst_step #(.AW(AW), .SZ_W(SZ_W)) u_step (
    .addr_i (addr_q),
    .size_i (beat_sz),
    .desc_i (desc_q),
    .last_i (pick_last),
    .addr_o (next_addr)
  );

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      busy_q  <= 1'b0;
      wb_q    <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      fin_q   <= '0;
      desc_q  <= 1'b0;
      store_q <= 1'b0;
      wide_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else if (!busy_q) begin
      wb_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        pend_q  <= sel_w;
        addr_q  <= base_addr_i;
        desc_q  <= desc_w;
        store_q <= store_w;
        wide_q  <= wide_fmt_i;
        upd_q   <= ea_update_i;
      end
    end else if (pend_q == '0) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      wb_q   <= upd_q;
      fin_q  <= addr_q;
    end else if (mem_ready_i) begin
      pend_q[pick_idx] <= 1'b0;
      addr_q           <= next_addr;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign wb_en_o      = wb_q;
  assign final_addr_o = fin_q;
  assign mem_req_o    = busy_q && (pend_q != '0);
  assign mem_write_o  = store_q;
  assign mem_idx_o    = pick_idx;
  assign mem_addr_o   = addr_q;
  assign mem_size_o   = beat_sz;

  // R6: a request lives only inside a busy window
  p_req_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R6: a stalled beat holds its index and address
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_idx_o) && $stable(mem_addr_o)));

  // R3: ascending order visits strictly increasing register indices
  p_asc_order_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ready_i && !desc_q) |=> (!mem_req_o || (mem_idx_o > $past(mem_idx_o))));

  // R4: descending order visits strictly decreasing register indices
  p_desc_order_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ready_i && desc_q) |=> (!mem_req_o || (mem_idx_o < $past(mem_idx_o))));

  // R8: done is one cycle wide and never overlaps busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R9: write-back enable only accompanies done
  p_wb_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> done_o);
endmodule

// File: tb/sim_fpr_burst_seq.sv
`timescale 1ns/1ps
module sim_fpr_burst_seq;
  localparam int NREG = 8;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            start_i, ext_dir_i, wide_fmt_i, ea_update_i, mem_ready_i;
  logic [1:0]      ext_mode_i;
  logic [NREG-1:0] ext_mask_i, reg_mask_i;
  logic [AW-1:0]   base_addr_i;
  logic            busy_o, done_o, wb_en_o, mem_req_o, mem_write_o;
  logic [AW-1:0]   final_addr_o, mem_addr_o;
  logic [2:0]      mem_idx_o;
  logic [3:0]      mem_size_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  fpr_burst_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .ext_dir_i(ext_dir_i),
    .ext_mode_i(ext_mode_i), .ext_mask_i(ext_mask_i), .reg_mask_i(reg_mask_i),
    .base_addr_i(base_addr_i), .wide_fmt_i(wide_fmt_i), .ea_update_i(ea_update_i),
    .busy_o(busy_o), .done_o(done_o), .final_addr_o(final_addr_o), .wb_en_o(wb_en_o),
    .mem_req_o(mem_req_o), .mem_ready_i(mem_ready_i), .mem_write_o(mem_write_o),
    .mem_idx_o(mem_idx_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // One transfer: drive start, follow every beat, check completion.
  task automatic run_op(input bit dir, input logic [1:0] mode, input logic [7:0] mask,
                        input bit wide, input bit upd, input logic [31:0] base,
                        input bit poke);
    bit          desc;
    int          seq[8];
    int          n, k, cyc;
    logic [31:0] sz, exp_addr, exp_fin;
    bit          acc, poked;

    desc = dir && !mode[1];
    n = 0;
    for (int i = 0; i < 8; i++) begin
      int r;
      r = desc ? 7 - i : i;
      if (desc ? mask[r] : mask[7-r]) begin
        seq[n] = r;
        n++;
      end
    end
    sz = wide ? 32'd12 : 32'd8;
    exp_fin = desc ? ((n == 0) ? base : base - 32'(n - 1) * sz) : base + 32'(n) * sz;

    @(negedge clk);
    start_i     = 1'b1;
    ext_dir_i   = dir;
    ext_mode_i  = mode;
    ext_mask_i  = mode[0] ? ~mask : mask;  // R1: unused source carries inverse
    reg_mask_i  = mode[0] ? mask : ~mask;
    wide_fmt_i  = wide;
    ea_update_i = upd;
    base_addr_i = base;
    mem_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    k = 0; cyc = 0; exp_addr = base; poked = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", {63'd0, busy_o}, 64'd1);
    forever begin
      if (done_o) begin
        check(k == n, "R3/R4 beat count", 64'(k), 64'(n));
        check(final_addr_o == exp_fin, desc ? "R4 final address" : "R3 final address",
              {32'd0, final_addr_o}, {32'd0, exp_fin});
        check(wb_en_o == upd, "R9 write-back enable", {63'd0, wb_en_o}, {63'd0, upd});
        check(busy_o == 1'b0, "R8 busy low at done", {63'd0, busy_o}, 64'd0);
        if (n == 0) check(cyc == 1, "R7 empty mask done timing", 64'(cyc), 64'd1);
        break;
      end
      if (poke && !poked && k == 1) begin
        start_i = 1'b1;  // R8: must be ignored while busy
        base_addr_i = ~base;
        ext_dir_i = ~dir;
        ext_mask_i = 8'hFF;
        reg_mask_i = 8'hFF;
        wide_fmt_i = ~wide;
        poked = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (mem_req_o) begin
        if (k >= n) begin
          check(1'b0, "R7 unexpected beat", {61'd0, mem_idx_o}, 64'd0);
        end else begin
          check(mem_idx_o == seq[k][2:0], desc ? "R4 register index" : "R3 register index",
                {61'd0, mem_idx_o}, 64'(seq[k]));
          check(mem_addr_o == exp_addr, desc ? "R4 beat address" : "R3 beat address",
                {32'd0, mem_addr_o}, {32'd0, exp_addr});
          check(mem_size_o == sz[3:0], "R5 beat size", {60'd0, mem_size_o}, {32'd0, sz});
          check(mem_write_o == dir, "R2 write flag", {63'd0, mem_write_o}, {63'd0, dir});
        end
      end else begin
        check(busy_o == 1'b1, "R8 busy while working", {63'd0, busy_o}, 64'd1);
      end
      mem_ready_i = lfsr[0] | lfsr[1];  // R6: stall about a quarter of cycles
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc = mem_req_o && mem_ready_i;
      if (acc && k < n) begin
        k++;
        if (!desc) exp_addr = exp_addr + sz;
        else if (k < n) exp_addr = exp_addr - sz;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 200) begin
        check(1'b0, "R6 transfer watchdog", 64'(cyc), 64'd200);
        break;
      end
    end
    start_i = 1'b0;
    mem_ready_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single pulse", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL global watchdog expired");
    summary();
  end

  initial begin
    rst = 1'b1; start_i = 1'b1; ext_dir_i = 1'b0; ext_mode_i = 2'd0;
    ext_mask_i = 8'hFF; reg_mask_i = 8'hFF; base_addr_i = 32'h100;
    wide_fmt_i = 1'b0; ea_update_i = 1'b1; mem_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R10 reset busy", {63'd0, busy_o}, 64'd0);
    check(done_o == 1'b0, "R10 reset done", {63'd0, done_o}, 64'd0);
    check(mem_req_o == 1'b0, "R10 reset request", {63'd0, mem_req_o}, 64'd0);
    check(wb_en_o == 1'b0, "R10 reset write-back", {63'd0, wb_en_o}, 64'd0);
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R7 R9 sweep
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int m = 0; m < 256; m++) begin
        run_op(cfg[0], cfg[2:1], m[7:0], cfg[3], m[0] ^ cfg[1],
               32'h8000_0000 ^ (32'(m) << 4) ^ (32'(cfg) << 16), 1'b0);
      end
    end
    // R8 stray start during a transfer, both orders
    run_op(1'b1, 2'b00, 8'hF0, 1'b1, 1'b1, 32'h0000_4000, 1'b1);
    run_op(1'b0, 2'b01, 8'h5A, 1'b0, 1'b0, 32'h0000_0010, 1'b1);
    // R4 descending address wrap below zero
    run_op(1'b1, 2'b00, 8'hFF, 1'b1, 1'b1, 32'h0000_0010, 1'b0);
    summary();
  end
endmodule